// File: doc/BRIEF.md
# Streaming Radix-4 Decimation-in-Frequency Stage

This block is one stage of a pipelined radix-4 decimation-in-frequency FFT. Complex samples enter in natural order, at most one per clock, and leave as a continuous stream with no stalls between frames. Within every frame of N points the stage brings together the four samples spaced N/4 apart. It combines them in a radix-4 butterfly, scales the result by one quarter, and rotates each butterfly output by its twiddle factor. All outputs pass through one shared complex multiplier.

The first three quarters of a frame fill three delay lanes of depth N/4. During the fourth quarter, each arriving sample completes a butterfly. The zero-index output of that butterfly leaves at once. The other three outputs are written back into the lanes. They drain, rotated, during the first three quarters of the next frame. The run-time size is given as a power-of-four exponent and is adopted only between frames. A 2048-point transform needs an extra radix-2 stage outside this block.

Top module: `r4dif_stage`

## Requirements
- R1: While rst_n is low and on the first cycle after it, out_valid is 0 and out_re/out_im are 0. Reset selects the largest size, LOG4_MAX.
- R2: A frame is exactly N = 4^L accepted samples, counted only on cycles with in_valid high. Cycles with in_valid low leave the count and the output stream unchanged.
- R3: After reset or a size change, the first 3N/4 samples of a frame produce no output.
- R4: Every output appears exactly two clock cycles after the accepted sample that triggered it. No output appears in any other cycle.
- R5: With x0..x3 the samples at in-frame positions n, n+N/4, n+2N/4 and n+3N/4, the butterfly forms y0=x0+x1+x2+x3, y1=x0-jx1-x2+jx3, y2=x0-x1+x2-x3 and y3=x0+jx1-x2-jx3. Each real and imaginary part is then shifted right arithmetically by 2, rounding toward minus infinity.
- R6: Output order is as follows. During the fourth quarter of frame f, y0[n] for n ascending. During the first, second and third quarters of frame f+1, y1[n], y2[n] and y3[n] of frame f.
- R7: Output k at index n equals yk[n]·exp(-j2πkn/N), rounded, within 2 LSB. When kn is 0 the output is bit-exact.
- R8: Each rotated part saturates to the range -32768..32767 instead of wrapping.
- R9: size_log4 is sampled only when the in-frame count is 0. A new value starts a fresh frame and discards the three pending outputs of the previous frame. A change during a frame has no effect until that frame completes.
- R10: size_log4 values below LOG4_MIN or above LOG4_MAX are clamped to that limit. The defaults are 2 and 5, giving N from 16 to 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| size_log4 | input | SELW (3) | Transform size as exponent L, N = 4^L |
| in_valid | input | 1 | Input sample valid |
| in_re | input | DATA_W (16) | Input real part, signed |
| in_im | input | DATA_W (16) | Input imaginary part, signed |
| out_valid | output | 1 | Output sample valid |
| out_re | output | DATA_W (16) | Output real part, signed |
| out_im | output | DATA_W (16) | Output imaginary part, signed |

## Verification
Properties check the following on every cycle: the two-cycle relation between accepted input and output, the in-frame count staying below the active N, size changes happening only at count 0, the clamped size range, silence while an unprimed frame fills, and bit-exact unity rotation. Only the scenarios can show that the butterfly arithmetic, the twiddle values, the order of the four output groups, saturation, dropping of a pending tail on resize, and tolerance of input gaps match the model. The bench computes that model itself for 16-, 64- and 1024-point frames.

// File: rtl/r4s_pkg.sv
package r4s_pkg;
    localparam int R4_POINTS = 4;
    localparam int R4_LANES  = 3;

    typedef enum logic [1:0] {
        QTR_FILL0 = 2'd0,
        QTR_FILL1 = 2'd1,
        QTR_FILL2 = 2'd2,
        QTR_BFLY  = 2'd3
    } r4_quarter_e;
endpackage

// File: rtl/r4s_butterfly.sv
module r4s_butterfly #(
    parameter int DATA_W = 16
) (
    input  logic signed [DATA_W-1:0] xr [r4s_pkg::R4_POINTS],
    input  logic signed [DATA_W-1:0] xi [r4s_pkg::R4_POINTS],
    output logic signed [DATA_W-1:0] yr [r4s_pkg::R4_POINTS],
    output logic signed [DATA_W-1:0] yi [r4s_pkg::R4_POINTS]
);
    localparam int SW = DATA_W + 2;

    logic signed [SW-1:0] ar [r4s_pkg::R4_POINTS];
    logic signed [SW-1:0] ai [r4s_pkg::R4_POINTS];
    logic signed [SW-1:0] sr [r4s_pkg::R4_POINTS];
    logic signed [SW-1:0] si [r4s_pkg::R4_POINTS];

    always_comb begin
        for (int m = 0; m < r4s_pkg::R4_POINTS; m++) begin
            ar[m] = SW'(xr[m]);
            ai[m] = SW'(xi[m]);
        end
        sr[0] = ar[0] + ar[1] + ar[2] + ar[3];
        si[0] = ai[0] + ai[1] + ai[2] + ai[3];
        // -j rotation of x1, +j rotation of x3
        sr[1] = ar[0] + ai[1] - ar[2] - ai[3];
        si[1] = ai[0] - ar[1] - ai[2] + ar[3];
        sr[2] = ar[0] - ar[1] + ar[2] - ar[3];
        si[2] = ai[0] - ai[1] + ai[2] - ai[3];
        sr[3] = ar[0] - ai[1] - ar[2] + ai[3];
        si[3] = ai[0] + ar[1] - ai[2] - ar[3];
        for (int m = 0; m < r4s_pkg::R4_POINTS; m++) begin
            yr[m] = DATA_W'(sr[m] >>> 2);
            yi[m] = DATA_W'(si[m] >>> 2);
        end
    end
endmodule

// File: rtl/r4s_twiddle.sv
module r4s_twiddle #(
    parameter int ANGLE_W = 10,
    parameter int COEF_W  = 17
) (
    input  logic [ANGLE_W-1:0]       angle,
    output logic signed [COEF_W-1:0] cos_o,
    output logic signed [COEF_W-1:0] sin_o
);
    localparam int  QW   = ANGLE_W - 2;
    localparam int  QLEN = 1 << QW;
    localparam real PI   = 3.14159265358979323846;
    localparam real ONE  = real'(1 << (COEF_W - 2));

    logic signed [COEF_W-1:0] tab [QLEN+1];

    for (genvar i = 0; i <= QLEN; i++) begin : g_tab
        localparam real ANG = 2.0 * PI * i / (4.0 * QLEN);
        localparam int  VAL = $rtoi($cos(ANG) * ONE + 0.5);
        assign tab[i] = COEF_W'(VAL);
    end

    logic [1:0]    quad;
    logic [QW-1:0] r_idx;
    logic [QW:0]   r_mir;
    logic signed [COEF_W-1:0] c_f, s_f;

    always_comb begin
        quad  = angle[ANGLE_W-1 -: 2];
        r_idx = angle[QW-1:0];
        r_mir = (QW+1)'(QLEN) - {1'b0, r_idx};
        c_f   = tab[r_idx];
        s_f   = tab[r_mir];
        unique case (quad)
            2'd0:    begin cos_o =  c_f; sin_o =  s_f; end
            2'd1:    begin cos_o = -s_f; sin_o =  c_f; end
            2'd2:    begin cos_o = -c_f; sin_o = -s_f; end
            default: begin cos_o =  s_f; sin_o = -c_f; end
        endcase
    end
endmodule

// File: rtl/r4s_cmul.sv
module r4s_cmul #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 17
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] d_re,
    input  logic signed [DATA_W-1:0] d_im,
    input  logic signed [COEF_W-1:0] c,
    input  logic signed [COEF_W-1:0] s,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_re,
    output logic signed [DATA_W-1:0] out_im
);
    localparam int FR = COEF_W - 2;
    localparam int PW = DATA_W + COEF_W + 2;
    localparam int TW = PW - FR;
    localparam logic signed [TW-1:0] MAXV = TW'((1 << (DATA_W - 1)) - 1);
    localparam logic signed [TW-1:0] MINV = -TW'(1 << (DATA_W - 1));

    typedef struct packed {
        logic                     vld;
        logic signed [DATA_W-1:0] re;
        logic signed [DATA_W-1:0] im;
    } cm_state_t;

    cm_state_t st_d, st_q;
    logic signed [PW-1:0] p_re, p_im;
    logic signed [TW-1:0] t_re, t_im;

    function automatic logic signed [DATA_W-1:0] clip(input logic signed [TW-1:0] v);
        if (v > MAXV)      return DATA_W'(MAXV);
        else if (v < MINV) return DATA_W'(MINV);
        else               return DATA_W'(v);
    endfunction

    // (a + jb)(c - js) = (ac + bs) + j(bc - as)
    always_comb begin
        p_re = PW'(d_re) * PW'(c) + PW'(d_im) * PW'(s) + PW'(1 << (FR - 1));
        p_im = PW'(d_im) * PW'(c) - PW'(d_re) * PW'(s) + PW'(1 << (FR - 1));
        t_re = TW'(p_re >>> FR);
        t_im = TW'(p_im >>> FR);
        st_d.vld = in_valid;
        st_d.re  = in_valid ? clip(t_re) : st_q.re;
        st_d.im  = in_valid ? clip(t_im) : st_q.im;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_re    = st_q.re;
    assign out_im    = st_q.im;
endmodule

// File: rtl/r4dif_stage.sv
module r4dif_stage #(
    parameter int LOG4_MIN = 2,
    parameter int LOG4_MAX = 5,
    parameter int DATA_W   = 16,
    parameter int COEF_W   = 17,
    parameter int SELW     = $clog2(LOG4_MAX + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SELW-1:0]          size_log4,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_re,
    input  logic signed [DATA_W-1:0] in_im,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_re,
    output logic signed [DATA_W-1:0] out_im
);
    import r4s_pkg::*;

    localparam int CW   = 2 * LOG4_MAX;
    localparam int QW   = CW - 2;
    localparam int QMAX = 1 << QW;
    localparam int WW   = 2 * DATA_W;

    typedef struct packed {
        logic [CW-1:0]            cnt;
        logic [SELW-1:0]          lsz;
        logic                     primed;
        logic                     a_valid;
        logic signed [DATA_W-1:0] a_re;
        logic signed [DATA_W-1:0] a_im;
        logic [CW-1:0]            a_exp;
    } stage_state_t;

    stage_state_t st_d, st_q;

    logic [SELW-1:0]   size_clamped, lsz;
    logic              size_chg, primed, last;
    int                qshift;
    logic [CW-1:0]     nmask, e_k;
    logic [QW-1:0]     n_idx;
    r4_quarter_e       quarter;
    logic [R4_LANES-1:0] wr_en;
    logic [WW-1:0]     wr_data [R4_LANES];
    logic [WW-1:0]     rd_word [R4_LANES];
    logic signed [DATA_W-1:0] bx_re [R4_POINTS];
    logic signed [DATA_W-1:0] bx_im [R4_POINTS];
    logic signed [DATA_W-1:0] by_re [R4_POINTS];
    logic signed [DATA_W-1:0] by_im [R4_POINTS];
    logic signed [COEF_W-1:0] tw_c, tw_s;

    for (genvar j = 0; j < R4_LANES; j++) begin : g_lane
        logic [WW-1:0] mem [QMAX];
        always_ff @(posedge clk) begin
            if (wr_en[j]) mem[n_idx] <= wr_data[j];
        end
        assign rd_word[j] = mem[n_idx];
    end

    always_comb begin
        for (int m = 0; m < R4_LANES; m++) begin
            bx_re[m] = rd_word[m][WW-1:DATA_W];
            bx_im[m] = rd_word[m][DATA_W-1:0];
        end
        bx_re[R4_POINTS-1] = in_re;
        bx_im[R4_POINTS-1] = in_im;
    end

    r4s_butterfly #(.DATA_W(DATA_W)) u_bfly (
        .xr(bx_re), .xi(bx_im), .yr(by_re), .yi(by_im)
    );

    always_comb begin
        if (int'(size_log4) < LOG4_MIN)      size_clamped = SELW'(LOG4_MIN);
        else if (int'(size_log4) > LOG4_MAX) size_clamped = SELW'(LOG4_MAX);
        else                                 size_clamped = size_log4;
        size_chg = (st_q.cnt == '0) && (size_clamped != st_q.lsz);
        lsz      = size_chg ? size_clamped : st_q.lsz;
        primed   = size_chg ? 1'b0 : st_q.primed;
        qshift   = 2 * int'(lsz) - 2;
        nmask    = (CW'(1) << qshift) - CW'(1);
        quarter  = r4_quarter_e'(2'(st_q.cnt >> qshift));
        n_idx    = QW'(st_q.cnt & nmask);
        last     = (quarter == QTR_BFLY) && ((st_q.cnt & nmask) == nmask);
        e_k      = CW'(quarter) + CW'(1);

        st_d         = st_q;
        st_d.lsz     = lsz;
        st_d.primed  = primed;
        st_d.a_valid = 1'b0;
        wr_en        = '0;
        for (int m = 0; m < R4_LANES; m++) wr_data[m] = '0;

        if (in_valid) begin
            st_d.cnt = last ? '0 : st_q.cnt + CW'(1);
            if (quarter == QTR_BFLY) begin
                wr_en = '1;
                for (int m = 0; m < R4_LANES; m++)
                    wr_data[m] = {by_re[m+1], by_im[m+1]};
                st_d.a_valid = 1'b1;
                st_d.a_re    = by_re[0];
                st_d.a_im    = by_im[0];
                st_d.a_exp   = '0;
                if (last) st_d.primed = 1'b1;
            end else begin
                wr_en[quarter]   = 1'b1;
                wr_data[quarter] = {in_re, in_im};
                st_d.a_valid = primed;
                st_d.a_re    = rd_word[quarter][WW-1:DATA_W];
                st_d.a_im    = rd_word[quarter][DATA_W-1:0];
                st_d.a_exp   = (e_k * CW'(n_idx)) << (CW - 2 * int'(lsz));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.lsz <= SELW'(LOG4_MAX);
        end else begin
            st_q <= st_d;
        end
    end

    r4s_twiddle #(.ANGLE_W(CW), .COEF_W(COEF_W)) u_twid (
        .angle(st_q.a_exp), .cos_o(tw_c), .sin_o(tw_s)
    );

    r4s_cmul #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_cmul (
        .clk(clk), .rst_n(rst_n), .in_valid(st_q.a_valid),
        .d_re(st_q.a_re), .d_im(st_q.a_im), .c(tw_c), .s(tw_s),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

    logic [CW-1:0]            cnt_q;
    logic [SELW-1:0]          lsz_q;
    logic                     primed_q, a_valid_q;
    logic signed [DATA_W-1:0] a_re_q, a_im_q;
    logic [CW-1:0]            a_exp_q;
    assign cnt_q     = st_q.cnt;
    assign lsz_q     = st_q.lsz;
    assign primed_q  = st_q.primed;
    assign a_valid_q = st_q.a_valid;
    assign a_re_q    = st_q.a_re;
    assign a_im_q    = st_q.a_im;
    assign a_exp_q   = st_q.a_exp;
endmodule

// File: rtl/r4dif_stage_chk.sv
module r4dif_stage_chk #(
    parameter int LOG4_MIN = 2,
    parameter int LOG4_MAX = 5,
    parameter int DATA_W   = 16,
    parameter int SELW     = 3,
    parameter int CW       = 10
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_re,
    input logic signed [DATA_W-1:0] out_im,
    input logic [CW-1:0]            cnt_q,
    input logic [SELW-1:0]          lsz_q,
    input logic                     primed_q,
    input logic                     a_valid_q,
    input logic signed [DATA_W-1:0] a_re_q,
    input logic signed [DATA_W-1:0] a_im_q,
    input logic [CW-1:0]            a_exp_q
);
    int frame_len, fill_len;
    assign frame_len = 1 << (2 * int'(lsz_q));
    assign fill_len  = 3 * (frame_len / 4);

    AST_LATENCY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2)); // R4

    AST_COUNT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < frame_len); // R2

    AST_SIZE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lsz_q) |-> $past(cnt_q) == '0); // R9

    AST_SIZE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(lsz_q) >= LOG4_MIN && int'(lsz_q) <= LOG4_MAX); // R10

    AST_QUIET_WHILE_FILLING: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !primed_q && int'(cnt_q) < fill_len) |=> !a_valid_q); // R3

    AST_UNITY_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid_q && a_exp_q == '0) |=>
            (out_valid && out_re == $past(a_re_q) && out_im == $past(a_im_q))); // R7
endmodule

bind r4dif_stage r4dif_stage_chk #(
    .LOG4_MIN(LOG4_MIN), .LOG4_MAX(LOG4_MAX), .DATA_W(DATA_W),
    .SELW(SELW), .CW(2 * LOG4_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im),
    .cnt_q(cnt_q), .lsz_q(lsz_q), .primed_q(primed_q),
    .a_valid_q(a_valid_q), .a_re_q(a_re_q), .a_im_q(a_im_q),
    .a_exp_q(a_exp_q)
);

// File: tb/r4dif_stage_test.sv
`timescale 1ns/1ps
module r4dif_stage_test;
    localparam int DW    = 16;
    localparam int SELW  = 3;
    localparam int DEPTH = 4096;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [SELW-1:0]      size_log4 = 3'd2;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_re = '0, in_im = '0;
    logic                 out_valid;
    logic signed [DW-1:0] out_re, out_im;

    r4dif_stage uut (
        .clk(clk), .rst_n(rst_n), .size_log4(size_log4), .in_valid(in_valid),
        .in_re(in_re), .in_im(in_im), .out_valid(out_valid),
        .out_re(out_re), .out_im(out_im)
    );

    always #4 clk = ~clk;

    int checks = 0, failures = 0;
    int cyc = 0, last_drv = 0;
    int ncap = 0, nexp = 0;
    int cap_re [DEPTH], cap_im [DEPTH], cap_cyc [DEPTH];
    int exp_re [DEPTH], exp_im [DEPTH], exp_tol [DEPTH];
    int din_re [DEPTH], din_im [DEPTH];
    int seed = 7;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && out_valid && ncap < DEPTH) begin
            cap_re[ncap]  = int'(out_re);
            cap_im[ncap]  = int'(out_im);
            cap_cyc[ncap] = cyc;
            ncap++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return int'((seed >> 16) & 32'h7FFF) - 16384;
    endfunction

    function automatic int sat_round(input real x);
        int v;
        v = $rtoi($floor(x + 0.5));
        if (v > 32767)  v = 32767;
        if (v < -32768) v = -32768;
        return v;
    endfunction

    // Model of R5/R6/R7/R8: appends the first 'limit' outputs of a frame.
    task automatic build_exp(input int base, input int lg, input int limit);
        int nn, qq, cnt;
        nn = 1 << (2 * lg);
        qq = nn / 4;
        cnt = 0;
        for (int k = 0; k < 4; k++) begin
            for (int n = 0; n < qq; n++) begin
                int r0, r1, r2, r3, i0, i1, i2, i3, yr, yi;
                real th;
                r0 = din_re[base+n];      i0 = din_im[base+n];
                r1 = din_re[base+n+qq];   i1 = din_im[base+n+qq];
                r2 = din_re[base+n+2*qq]; i2 = din_im[base+n+2*qq];
                r3 = din_re[base+n+3*qq]; i3 = din_im[base+n+3*qq];
                case (k)
                    0: begin yr = r0 + r1 + r2 + r3; yi = i0 + i1 + i2 + i3; end
                    1: begin yr = r0 + i1 - r2 - i3; yi = i0 - r1 - i2 + r3; end
                    2: begin yr = r0 - r1 + r2 - r3; yi = i0 - i1 + i2 - i3; end
                    default: begin yr = r0 - i1 - r2 + i3; yi = i0 + r1 - i2 - r3; end
                endcase
                yr = yr >>> 2;
                yi = yi >>> 2;
                th = 2.0 * 3.14159265358979323846 * real'(k * n) / real'(nn);
                if (cnt < limit) begin
                    exp_re[nexp]  = sat_round(real'(yr) * $cos(th) + real'(yi) * $sin(th));
                    exp_im[nexp]  = sat_round(real'(yi) * $cos(th) - real'(yr) * $sin(th));
                    exp_tol[nexp] = (k * n == 0) ? 0 : 2;
                    nexp++;
                end
                cnt++;
            end
        end
    endtask

    task automatic do_reset(input int lg);
        in_valid  = 1'b0;
        rst_n     = 1'b0;
        size_log4 = SELW'(lg);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ncap  = 0;
        nexp  = 0;
    endtask

    task automatic send(input int re, input int im);
        in_re    = DW'(re);
        in_im    = DW'(im);
        in_valid = 1'b1;
        last_drv = cyc;
        @(negedge clk);
    endtask

    task automatic stream(input int start, input int count, input bit gaps);
        for (int i = 0; i < count; i++) begin
            if (gaps && (i % 5 == 4)) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            send(din_re[start+i], din_im[start+i]);
        end
        in_valid = 1'b0;
    endtask

    task automatic fill_rand(input int start, input int count);
        for (int i = 0; i < count; i++) begin
            din_re[start+i] = rnd();
            din_im[start+i] = rnd();
        end
    endtask

    task automatic fill_zero(input int start, input int count);
        for (int i = 0; i < count; i++) begin
            din_re[start+i] = 0;
            din_im[start+i] = 0;
        end
    endtask

    task automatic compare_all(input string req);
        check(ncap == nexp, {req, " output count"}, ncap, nexp);
        for (int i = 0; i < nexp && i < ncap; i++) begin
            int dr, di;
            dr = cap_re[i] - exp_re[i];
            di = cap_im[i] - exp_im[i];
            if (dr < 0) dr = -dr;
            if (di < 0) di = -di;
            check(dr <= exp_tol[i], {req, " real part"}, cap_re[i], exp_re[i]);
            check(di <= exp_tol[i], {req, " imag part"}, cap_im[i], exp_im[i]);
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        in_valid = 1'b0;
        rst_n    = 1'b0;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        check(out_re == 0 && out_im == 0, "R1 data in reset", int'(out_re), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    endtask

    // R3 R4 R5 R6 R7 R8 on a 16-point frame with a saturating group
    task automatic t_first_frame();
        int drv12;
        do_reset(2);
        for (int i = 0; i < 16; i++) begin
            din_re[i] = 100 * i - 700;
            din_im[i] = 37 * i + 5;
        end
        din_re[2]  = 32767;  din_im[2]  = 32767;
        din_re[6]  = -32768; din_im[6]  = 32767;
        din_re[10] = -32768; din_im[10] = -32768;
        din_re[14] = 32767;  din_im[14] = -32768;
        fill_zero(16, 16);
        build_exp(0, 2, 16);
        build_exp(16, 2, 4);
        stream(0, 12, 1'b0);
        repeat (3) @(negedge clk);
        check(ncap == 0, "R3 silent while filling", ncap, 0);
        send(din_re[12], din_im[12]);
        drv12 = last_drv;
        stream(13, 19, 1'b0);
        repeat (8) @(negedge clk);
        check(ncap > 0 && cap_cyc[0] - drv12 == 2, "R4 two-cycle latency",
              cap_cyc[0] - drv12, 2);
        check(cap_re[6] == 32767, "R8 saturated real part", cap_re[6], 32767);
        compare_all("R5 R6 R7 16-point");
    endtask

    // R2 R6 with gaps in in_valid, two back-to-back 64-point frames
    task automatic t_gapped();
        do_reset(3);
        fill_rand(0, 128);
        fill_zero(128, 64);
        build_exp(0, 3, 64);
        build_exp(64, 3, 64);
        build_exp(128, 3, 16);
        stream(0, 192, 1'b1);
        repeat (8) @(negedge clk);
        compare_all("R2 R6 gapped 64-point");
    endtask

    // R9: size change requested mid-frame, adopted at the boundary
    task automatic t_resize();
        do_reset(2);
        fill_rand(0, 16);
        fill_rand(16, 64);
        fill_zero(80, 64);
        build_exp(0, 2, 4);
        build_exp(16, 3, 64);
        build_exp(80, 3, 16);
        stream(0, 8, 1'b0);
        size_log4 = 3'd3;
        stream(8, 8, 1'b0);
        stream(16, 48, 1'b0);
        repeat (3) @(negedge clk);
        check(ncap == 4, "R9 pending tail dropped on resize", ncap, 4);
        stream(64, 80, 1'b0);
        repeat (8) @(negedge clk);
        compare_all("R9 resize to 64-point");
    endtask

    // R10: out-of-range request clamps to the 1024-point maximum
    task automatic t_largest();
        do_reset(7);
        fill_rand(0, 1024);
        fill_zero(1024, 1024);
        build_exp(0, 5, 1024);
        build_exp(1024, 5, 256);
        stream(0, 2048, 1'b0);
        repeat (8) @(negedge clk);
        compare_all("R10 clamped 1024-point");
    endtask

    bit done = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_first_frame();
        t_gapped();
        t_resize();
        t_largest();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule